// File: doc/BRIEF.md
# Matrix-Multiply Accelerator Control Slave

This block is the host-facing front end of a small integer matrix-multiply engine. An AXI4-Lite slave gives software a control word, a size word and three windows of N×N signed 32-bit words: two operand matrices, called A and B, and one result matrix, called C. Software fills A and B, sets the start bit, polls the done bit and then reads C. Inside each window, element (i,j) sits at the window base plus 4·(i·N + j), so the elements are stored row by row.

The arithmetic engine sits outside this block. It receives a one-cycle launch pulse and returns a one-cycle completion pulse. While it runs, it reads A and B through two combinational index/data ports and writes each C element through a write port. The engine first clears every C element and then accumulates the products A[i][k]·B[k][j] over k. The block collects those writes in a staging array. When the engine completes, the staged values are copied into the host-visible C window. The host therefore never sees a matrix that is only partly computed.

The control word is at offset 0x00. Bit 0 is start: it reads 1 while a launch is pending and clears itself once the engine takes the launch. Bit 1 is done: it is sticky and is cleared by a read of the control word. Bit 2 is idle. Bit 7 is a host-writable auto-relaunch flag. A write to the control word changes only bits 0 and 7. The size word is at offset 0x10. The A window starts at 0x40, the B window at 0x80 and the C window at 0xC0.

Top module: `matmul_ctrl_slave`

## Requirements
- R1: After reset, the control word reads 0x00000004 (idle=1, all other bits 0), and the size word reads N (3).
- R2: Writes to A (0x40 + 4·idx) and B (0x80 + 4·idx) with idx = i·N + j are stored per byte under the write strobes and read back at the same offsets. The engine's read ports return the same values at the same idx.
- R3: Writing bit 0 = 1 to the control word while idle produces exactly one launch pulse. From then until completion, the control word reads idle=0.
- R4: After the completion pulse, the control word reads done=1 (bit 1) and idle=1 (bit 2). The next read of the control word returns done=0.
- R5: After completion, C window word idx reads Σk A[i][k]·B[k][j] as a 32-bit signed value, with the engine having written zero to every element first.
- R6: Writes to the A or B windows are ignored while the engine is busy, meaning from the accepted start until completion.
- R7: Reads of the C window while the engine is busy return the values from the last completed run, or zero if no run has completed.
- R8: Bit 7 of the control word is writable and sticky. While it is 1, every completion immediately launches the engine again. After it is written back to 0, the next completion launches nothing.
- R9: Accesses to unmapped offsets, including window slots with idx ≥ N·N, complete with response OKAY (0). Reads of them return zero and writes to them have no effect.
- R10: The write address and write data may arrive in either order or in the same cycle. Each write produces exactly one write response, and a response or read data item stays stable until it is accepted.
- R11: The size word honours the byte strobes: a write with strobe 4'b1100 changes only bits 31:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| awaddr | input | 8 | Write address |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Write byte strobes |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| bresp | output | 2 | Write response (always OKAY) |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| araddr | input | 8 | Read address |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response (always OKAY) |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| core_start | output | 1 | One-cycle launch pulse to the engine |
| core_done | input | 1 | One-cycle completion pulse from the engine |
| a_idx | input | 4 | Engine read index into A |
| a_data | output | 32 | A element at a_idx |
| b_idx | input | 4 | Engine read index into B |
| b_data | output | 32 | B element at b_idx |
| c_we | input | 1 | Engine write enable into C staging |
| c_idx | input | 4 | Engine write index into C |
| c_data | input | 32 | Engine write data for C |

## Verification
The hardest conditions to reach from the ports are the ones that exist only while the engine is busy. These are host writes to A, host reads of C before completion, and the automatic relaunch. The bench models the engine itself and holds it after each launch until the bench hands it a one-shot token. This turns the busy interval into a window of known length, in which the bench issues its ignored writes and stale reads. For auto-relaunch, the bench counts launch pulses, waits for the second one, and then clears bit 7 while that run is still held.

// File: rtl/matmul_ctrl_slave.sv
module matmul_ctrl_slave #(
  parameter int N  = 3,
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    awaddr,
  input  logic             awvalid,
  output logic             awready,
  input  logic [DW-1:0]    wdata,
  input  logic [DW/8-1:0]  wstrb,
  input  logic             wvalid,
  output logic             wready,
  output logic [1:0]       bresp,
  output logic             bvalid,
  input  logic             bready,
  input  logic [AW-1:0]    araddr,
  input  logic             arvalid,
  output logic             arready,
  output logic [DW-1:0]    rdata,
  output logic [1:0]       rresp,
  output logic             rvalid,
  input  logic             rready,
  output logic             core_start,
  input  logic             core_done,
  input  logic [$clog2(N*N)-1:0] a_idx,
  output logic [DW-1:0]    a_data,
  input  logic [$clog2(N*N)-1:0] b_idx,
  output logic [DW-1:0]    b_data,
  input  logic             c_we,
  input  logic [$clog2(N*N)-1:0] c_idx,
  input  logic [DW-1:0]    c_data
);
  localparam int NE = N * N;
  localparam int IW = $clog2(NE);
  localparam int SW = DW / 8;
  localparam logic [1:0] WIN_A = 2'd1;
  localparam logic [1:0] WIN_B = 2'd2;
  localparam logic [1:0] WIN_C = 2'd3;

  logic [DW-1:0] mem_a [NE];
  logic [DW-1:0] mem_b [NE];
  logic [DW-1:0] c_stage [NE];
  logic [DW-1:0] c_vis [NE];
  logic [DW-1:0] size_q;
  logic auto_q, start_q, busy_q, done_q;

  logic          aw_have, w_have;
  logic [AW-1:0] aw_q;
  logic [DW-1:0] w_q;
  logic [SW-1:0] ws_q;

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                          input logic [SW-1:0] s);
    logic [DW-1:0] r;
    for (int k = 0; k < SW; k++) r[k*8 +: 8] = s[k] ? n[k*8 +: 8] : o[k*8 +: 8];
    return r;
  endfunction

  wire idle   = !busy_q && !start_q;
  wire aw_fire = awvalid && awready;
  wire w_fire  = wvalid && wready;
  wire aw_ok  = aw_have || aw_fire;
  wire w_ok   = w_have || w_fire;
  wire wr_go  = aw_ok && w_ok && !bvalid;

  wire [AW-1:0] wa  = aw_have ? aw_q : awaddr;
  wire [DW-1:0] wd  = w_have ? w_q : wdata;
  wire [SW-1:0] wst = w_have ? ws_q : wstrb;
  wire [3:0]    wi  = wa[5:2];
  wire          w_in = (int'(wi) < NE);
  wire          w_ctl = wr_go && (wa[7:2] == 6'h00);
  wire          w_siz = wr_go && (wa[7:2] == 6'h04);
  wire          w_a   = wr_go && idle && (wa[7:6] == WIN_A) && w_in;
  wire          w_b   = wr_go && idle && (wa[7:6] == WIN_B) && w_in;

  wire          ar_fire = arvalid && arready;
  wire [3:0]    ri   = araddr[5:2];
  wire          r_in = (int'(ri) < NE);
  wire          r_ctl = ar_fire && (araddr[7:2] == 6'h00);

  wire unused_ok = &{1'b0, wa[1:0], araddr[1:0]};

  assign awready    = !aw_have && !bvalid;
  assign wready     = !w_have && !bvalid;
  assign arready    = !rvalid;
  assign bresp      = 2'b00;
  assign rresp      = 2'b00;
  assign core_start = start_q;
  assign a_data     = (int'(a_idx) < NE) ? mem_a[a_idx] : '0;
  assign b_data     = (int'(b_idx) < NE) ? mem_b[b_idx] : '0;

  logic [DW-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (araddr[7:2] == 6'h00) begin
      rd_val[0] = start_q;
      rd_val[1] = done_q;
      rd_val[2] = idle;
      rd_val[7] = auto_q;
    end else if (araddr[7:2] == 6'h04) begin
      rd_val = size_q;
    end else if (r_in) begin
      case (araddr[7:6])
        WIN_A:   rd_val = mem_a[ri[IW-1:0]];
        WIN_B:   rd_val = mem_b[ri[IW-1:0]];
        WIN_C:   rd_val = c_vis[ri[IW-1:0]];
        default: rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_have <= 1'b0;
      w_have  <= 1'b0;
      aw_q    <= '0;
      w_q     <= '0;
      ws_q    <= '0;
      bvalid  <= 1'b0;
    end else begin
      if (wr_go) begin
        aw_have <= 1'b0;
        w_have  <= 1'b0;
        bvalid  <= 1'b1;
      end else begin
        if (aw_fire) begin
          aw_have <= 1'b1;
          aw_q    <= awaddr;
        end
        if (w_fire) begin
          w_have <= 1'b1;
          w_q    <= wdata;
          ws_q   <= wstrb;
        end
        if (bvalid && bready) bvalid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else if (ar_fire) begin
      rvalid <= 1'b1;
      rdata  <= rd_val;
    end else if (rvalid && rready) begin
      rvalid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_q  <= DW'(N);
      auto_q  <= 1'b0;
      start_q <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      for (int k = 0; k < NE; k++) begin
        mem_a[k]   <= '0;
        mem_b[k]   <= '0;
        c_stage[k] <= '0;
        c_vis[k]   <= '0;
      end
    end else begin
      if (start_q) begin
        start_q <= 1'b0;
        busy_q  <= 1'b1;
      end
      if (w_ctl && wst[0]) begin
        auto_q <= wd[7];
        if (wd[0] && idle) start_q <= 1'b1;
      end
      if (w_siz) size_q <= merge(size_q, wd, wst);
      if (w_a) mem_a[wi[IW-1:0]] <= merge(mem_a[wi[IW-1:0]], wd, wst);
      if (w_b) mem_b[wi[IW-1:0]] <= merge(mem_b[wi[IW-1:0]], wd, wst);
      if (c_we && int'(c_idx) < NE) c_stage[c_idx] <= c_data;
      if (r_ctl) done_q <= 1'b0;
      if (core_done && busy_q) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        for (int k = 0; k < NE; k++) c_vis[k] <= c_stage[k];
        if (auto_q) start_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/matmul_ctrl_slave_chk.sv
module matmul_ctrl_slave_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bvalid,
  input logic          bready,
  input logic [1:0]    bresp,
  input logic          rvalid,
  input logic          rready,
  input logic [1:0]    rresp,
  input logic [DW-1:0] rdata,
  input logic          core_start,
  input logic          core_done,
  input logic          busy_q
);
  // R10
  bresp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid && !bready |=> bvalid);
  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && !rready |=> rvalid && $stable(rdata));
  // R9
  bresp_okay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> bresp == 2'b00);
  // R9
  rresp_okay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> rresp == 2'b00);
  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start && busy_q);
  // R4
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_done && busy_q && !core_start |=> !busy_q);
endmodule

bind matmul_ctrl_slave matmul_ctrl_slave_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bvalid(bvalid), .bready(bready), .bresp(bresp),
  .rvalid(rvalid), .rready(rready), .rresp(rresp), .rdata(rdata),
  .core_start(core_start), .core_done(core_done), .busy_q(busy_q)
);

// File: tb/sim_matmul_ctrl_slave.sv
module sim_matmul_ctrl_slave;
  localparam int CLK_PERIOD = 10;
  localparam int N = 3;
  localparam int NE = N * N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] awaddr = '0, araddr = '0;
  logic awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0;
  logic bready = 1'b1, rready = 1'b1;
  logic [31:0] wdata = '0;
  logic [3:0] wstrb = '0;
  logic awready, wready, bvalid, arready, rvalid, core_start;
  logic [1:0] bresp, rresp;
  logic [31:0] rdata, a_data, b_data;
  logic core_done = 1'b0, c_we = 1'b0;
  logic [3:0] a_idx = '0, b_idx = '0, c_idx = '0;
  logic [31:0] c_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  matmul_ctrl_slave #(.N(N), .DW(32), .AW(8)) u0 (
    .clk(clk), .rst_n(rst_n),
    .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
    .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
    .bresp(bresp), .bvalid(bvalid), .bready(bready),
    .araddr(araddr), .arvalid(arvalid), .arready(arready),
    .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
    .core_start(core_start), .core_done(core_done),
    .a_idx(a_idx), .a_data(a_data), .b_idx(b_idx), .b_data(b_data),
    .c_we(c_we), .c_idx(c_idx), .c_data(c_data)
  );

  int n_tests = 0, n_fail = 0;
  int n_wr = 0, n_bresp = 0, start_cnt = 0;
  bit token = 0;
  bit finished = 0;
  int ma[NE], mb[NE];
  logic [31:0] exp_q[$];
  string tag_q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic int prod(input int i, input int j);
    int acc = 0;
    for (int k = 0; k < N; k++) acc += ma[i*N+k] * mb[k*N+j];
    return acc;
  endfunction

  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      logic [31:0] e;
      string t;
      if (exp_q.size() == 0) begin
        chk(0, "R10 unexpected read data", rdata, 32'h0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rdata === e && rresp == 2'b00, t, rdata, e);
      end
    end
    if (rst_n && bvalid) begin
      n_bresp++;
      chk(bresp == 2'b00, "R9 bresp OKAY", {30'h0, bresp}, 32'h0);
    end
  end

  task automatic wr(input logic [7:0] ad, input logic [31:0] d, input logic [3:0] s, input int mode);
    bit ad_done = 0, wd_done = 0, fa, fw;
    @(negedge clk);
    awaddr = ad; wdata = d; wstrb = s;
    awvalid = (mode != 2);
    wvalid = (mode != 1);
    while (!(ad_done && wd_done)) begin
      fa = awvalid && awready;
      fw = wvalid && wready;
      @(posedge clk);
      @(negedge clk);
      if (fa) begin awvalid = 0; ad_done = 1; end
      if (fw) begin wvalid = 0; wd_done = 1; end
      if (ad_done && !wd_done && !wvalid) wvalid = 1;
      if (wd_done && !ad_done && !awvalid) awvalid = 1;
    end
    n_wr++;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] ad, input logic [31:0] e, input string t);
    bit f;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    araddr = ad; arvalid = 1;
    do begin
      f = arready;
      @(posedge clk);
      @(negedge clk);
    end while (!f);
    arvalid = 0;
    @(negedge clk);
  endtask

  // engine model: holds each run until handed a token
  initial begin
    int acc;
    @(posedge rst_n);
    @(negedge clk);
    forever begin
      while (!core_start) @(negedge clk);
      start_cnt++;
      @(negedge clk);
      while (!token) @(negedge clk);
      token = 0;
      for (int k = 0; k < NE; k++) begin
        c_we = 1; c_idx = 4'(k); c_data = 0;
        @(negedge clk);
      end
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) begin
          acc = 0;
          for (int k = 0; k < N; k++) begin
            a_idx = 4'(i*N+k); b_idx = 4'(k*N+j);
            #1;
            acc += $signed(a_data) * $signed(b_data);
          end
          c_we = 1; c_idx = 4'(i*N+j); c_data = acc;
          @(negedge clk);
        end
      c_we = 0;
      core_done = 1;
      @(negedge clk);
      core_done = 0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h1, 32'h0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int base;
    int old4;
    ma = '{2, -1, 0, 3, 4, -5, 1, 0, 7};
    mb = '{1, 2, 3, -2, 0, 4, 5, -3, 1};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    rd(8'h00, 32'h4, "R1 ctrl reset");
    rd(8'h10, 32'd3, "R1 size reset");

    for (int k = 0; k < NE; k++) wr(8'(8'h40 + 4*k), ma[k], 4'hF, k % 3);
    for (int k = 0; k < NE; k++) wr(8'(8'h80 + 4*k), mb[k], 4'hF, (k + 1) % 3);
    rd(8'h50, ma[4], "R2 A[1][1] readback");
    rd(8'ha0, mb[8], "R2 B[2][2] readback");
    wr(8'h40, 32'h11223344, 4'hF, 0);
    wr(8'h40, 32'hAABBCCDD, 4'b0010, 1);
    rd(8'h40, 32'h1122CC44, "R2 byte strobe on A");
    wr(8'h40, ma[0], 4'hF, 2);

    wr(8'h10, 32'hDEAD0000, 4'b1100, 0);
    rd(8'h10, 32'hDEAD0003, "R11 size strobe");

    wr(8'h30, 32'hFFFFFFFF, 4'hF, 0);
    rd(8'h30, 32'h0, "R9 unmapped read zero");
    wr(8'h64, 32'h12345678, 4'hF, 1);
    rd(8'h64, 32'h0, "R9 slot beyond N*N");

    base = start_cnt;
    wr(8'h00, 32'h1, 4'hF, 0);
    repeat (3) @(negedge clk);
    chk(start_cnt == base + 1, "R3 one launch", start_cnt, base + 1);
    rd(8'h00, 32'h0, "R3 busy not idle");
    wr(8'h44, 32'h77, 4'hF, 0);
    rd(8'h44, ma[1], "R6 A write ignored while busy");
    rd(8'hc0, 32'h0, "R7 C before first completion");
    token = 1;
    repeat (100) @(negedge clk);
    rd(8'h00, 32'h6, "R4 done and idle");
    rd(8'h00, 32'h4, "R4 done cleared by read");
    for (int k = 0; k < NE; k++) rd(8'(8'hc0 + 4*k), prod(k / N, k % N), "R5 product");

    old4 = prod(1, 1);
    ma[4] = -10;
    wr(8'h50, ma[4], 4'hF, 2);
    wr(8'h00, 32'h1, 4'hF, 1);
    repeat (3) @(negedge clk);
    rd(8'hd0, old4, "R7 stale C while busy");
    token = 1;
    repeat (100) @(negedge clk);
    rd(8'hd0, prod(1, 1), "R5 product after new A");
    rd(8'h00, 32'h6, "R4 second done");

    base = start_cnt;
    wr(8'h00, 32'h81, 4'hF, 0);
    token = 1;
    for (int t = 0; t < 500 && start_cnt < base + 2; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(start_cnt == base + 2, "R8 relaunch on done", start_cnt, base + 2);
    rd(8'h00, 32'h82, "R8 auto bit kept, done, busy");
    wr(8'h00, 32'h0, 4'hF, 0);
    token = 1;
    repeat (100) @(negedge clk);
    rd(8'h00, 32'h6, "R8 no relaunch after clear");
    chk(start_cnt == base + 2, "R8 launch count", start_cnt, base + 2);

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all reads answered", exp_q.size(), 0);
    chk(n_bresp == n_wr, "R10 one response per write", n_bresp, n_wr);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule